// File: doc/BRIEF.md
# Bitfield Extract Unit

This unit pulls a bit field out of a 32-bit operand and returns it as a full 32-bit word with the bits above the field filled. It has two modes. In byte mode the operand is rotated right by a whole number of bytes and the low byte is kept, zero-filled above. In field mode the caller supplies a start position and a width. The field is then moved to bit 0 and filled above with zeros or with copies of its top bit. The result matches a left shift followed by a logical or arithmetic right shift.

The unit sits beside an execute stage. A request is presented with `req_valid`, and the answer appears on `res_data` with `res_valid` on the next clock. Between requests the result register holds its last value.

Top module: `bitfield_extract_unit`

## Requirements
- R1: With `req_field` = 0 (byte mode), `req_rot` selects a right rotation of the operand: 00 → 0, 01 → 8, 10 → 16, 11 → 24 bits. The low 8 bits of the rotated word form the result, and bits 31..8 are zero.
- R2: In byte mode with `req_rot` = 00, the result equals the operand ANDed with 0xFF.
- R3: In byte mode `req_sext` is ignored. The result is always zero-filled above bit 7.
- R4: With `req_field` = 1 and `req_sext` = 0, and with pos + width ≤ 32, the result equals (operand << (32 − pos − width)) logically shifted right by (32 − width). Here pos is `req_pos` (0..31) and width is `req_width` (1..32, plain binary).
- R5: With `req_field` = 1 and `req_sext` = 1, the final right shift is arithmetic. Bit pos+width−1 of the operand is copied into every result bit from width upward.
- R6: When pos + width > 32, the field ends at bit 31 of the operand, and the effective width is 32 − pos. Zero or sign fill then applies above that effective width.
- R7: In field mode, pos = 0 with width = 32 returns the operand unchanged for either value of `req_sext`.
- R8: `res_valid` is high exactly one clock after a cycle with `req_valid` high, and low otherwise. In a cycle without `req_valid`, `res_data` keeps its previous value.
- R9: A synchronous active-high `rst` clears `res_valid` and `res_data` to zero at the next clock, even when `req_valid` is high in that cycle.
- R10: In field mode, a `req_width` of 0 gives a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_src | input | 32 | Source operand |
| req_field | input | 1 | 0 = byte mode, 1 = field mode |
| req_rot | input | 2 | Byte rotation code |
| req_pos | input | 5 | Field start bit |
| req_width | input | 6 | Field width, 1..32 |
| req_sext | input | 1 | Sign fill in field mode |
| res_valid | output | 1 | Result valid, one clock after the request |
| res_data | output | 32 | Extracted, filled result |

## Verification
Two things can land on the result register in the same cycle.

- **Back-to-back requests:** a new request arrives while the previous answer is being presented. The bench drives requests on consecutive clocks, switching between byte and field mode and between fills each time. Every clock, the bench compares the register against a behavioural bit-by-bit model. This shows that each answer belongs to the request one clock earlier and that nothing carries over from one request to the next.
- **Reset during a request:** the bench asserts reset while a request is present and expects zeros.

// File: rtl/bitfield_extract_unit.sv
module bitfield_extract_unit #(
  parameter int W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [W-1:0]               req_src,
  input  logic                       req_field,
  input  logic [1:0]                 req_rot,
  input  logic [$clog2(W)-1:0]       req_pos,
  input  logic [$clog2(W):0]         req_width,
  input  logic                       req_sext,
  output logic                       res_valid,
  output logic [W-1:0]               res_data
);
  localparam int PW = $clog2(W);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] WFULL = CW'(W);

  // byte mode
  logic [CW-1:0] rot_amt;
  logic [W-1:0]  rotated, byte_res;
  assign rot_amt  = CW'({req_rot, 3'b000});
  assign rotated  = (req_src >> rot_amt) | (req_src << (WFULL - rot_amt));
  assign byte_res = {{(W-8){1'b0}}, rotated[7:0]};

  // field mode: left shift then logical/arithmetic right shift
  logic [CW-1:0] room, eff, shl, shr;
  logic [W-1:0]  shifted, zres, sres, field_res;
  assign room    = WFULL - {1'b0, req_pos};
  assign eff     = (req_width > room) ? room : req_width;
  assign shl     = room - eff;
  assign shr     = WFULL - eff;
  assign shifted = req_src << shl;
  assign zres    = shifted >> shr;
  assign sres    = $signed(shifted) >>> shr;
  assign field_res = (eff == '0) ? '0 : (req_sext ? sres : zres);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) res_data <= req_field ? field_res : byte_res;
    end
  end

  p_byte_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_field) |=> (res_data[W-1:8] == '0));

  p_rot0_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_field && req_rot == 2'b00) |=> (res_data == ($past(req_src) & W'(255))));

  p_zero_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_field && !req_sext && req_width < CW'(W)) |=>
      ((res_data >> $past(req_width)) == '0));

  p_trunc_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_field && !req_sext && ({1'b0, req_pos} + req_width) > WFULL) |=>
      ((res_data >> (WFULL - {1'b0, $past(req_pos)})) == '0));

  p_full_word_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_field && req_pos == '0 && req_width == WFULL) |=>
      (res_data == $past(req_src)));

  p_valid_next_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!res_valid && $stable(res_data)));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0));
endmodule

// File: tb/bitfield_extract_unit_test.sv
`timescale 1ns/1ps
module bitfield_extract_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_src;
  logic        req_field;
  logic [1:0]  req_rot;
  logic [4:0]  req_pos;
  logic [5:0]  req_width;
  logic        req_sext;
  logic        res_valid;
  logic [31:0] res_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string cur_tag = "R9";

  logic        exp_valid = 1'b0;
  logic [31:0] exp_data  = '0;
  string       exp_tag   = "R9";

  always #2 clk = ~clk;

  bitfield_extract_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .req_field(req_field), .req_rot(req_rot), .req_pos(req_pos),
    .req_width(req_width), .req_sext(req_sext),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [31:0] model(input logic [31:0] s, input logic f,
      input logic [1:0] rot, input int pos, input int wid, input logic sx);
    logic [31:0] r = '0;
    int k, eff;
    if (!f) begin
      k = int'(rot) * 8;
      for (int i = 0; i < 8; i++) r[i] = s[k + i];
    end else begin
      eff = wid;
      if (pos + wid > 32) eff = 32 - pos;
      for (int i = 0; i < eff; i++) r[i] = s[pos + i];
      if (sx && eff > 0)
        for (int i = eff; i < 32; i++) r[i] = s[pos + eff - 1];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      exp_valid <= 1'b0;
      exp_data  <= '0;
      exp_tag   <= "R9";
    end else begin
      exp_valid <= req_valid;
      exp_tag   <= cur_tag;
      if (req_valid)
        exp_data <= model(req_src, req_field, req_rot, int'(req_pos), int'(req_width), req_sext);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (res_valid !== exp_valid) begin
        errors++;
        $display("FAIL %s/R8 valid: actual=%0b expected=%0b", exp_tag, res_valid, exp_valid);
      end
      checks++;
      if (res_data !== exp_data) begin
        errors++;
        $display("FAIL %s data: actual=%08h expected=%08h", exp_tag, res_data, exp_data);
      end
    end
  end

  task automatic req(input string tag, input logic v, input logic [31:0] s, input logic f,
      input logic [1:0] rot, input logic [4:0] pos, input logic [5:0] wid, input logic sx);
    cur_tag = tag;
    req_valid = v; req_src = s; req_field = f; req_rot = rot;
    req_pos = pos; req_width = wid; req_sext = sx;
    @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(100000 * 4);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b1; req_src = 32'hFFFF_FFFF; req_field = 1'b1;
    req_rot = 2'b00; req_pos = 5'd0; req_width = 6'd32; req_sext = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 each rotation code
    req("R1", 1, 32'hA1B2C3D4, 0, 2'b00, 0, 0, 0);
    req("R1", 1, 32'hA1B2C3D4, 0, 2'b01, 0, 0, 0);
    req("R1", 1, 32'hA1B2C3D4, 0, 2'b10, 0, 0, 0);
    req("R1", 1, 32'hA1B2C3D4, 0, 2'b11, 0, 0, 0);
    // R2 zero rotation is a mask
    req("R2", 1, 32'h1234_56FF, 0, 2'b00, 5'd7, 6'd3, 0);
    // R3 sext ignored in byte mode
    req("R3", 1, 32'h8080_8080, 0, 2'b00, 0, 0, 1);
    req("R3", 1, 32'hF0E0_D0C0, 0, 2'b11, 0, 0, 1);
    // idle cycle: data held (R8)
    req("R8", 0, 32'hDEAD_BEEF, 1, 2'b01, 5'd3, 6'd4, 1);
    req("R8", 0, 32'h0, 0, 2'b00, 0, 0, 0);
    // R4 / R5 general field
    req("R4", 1, 32'h0000_0F50, 1, 0, 5'd4, 6'd8, 0);
    req("R5", 1, 32'h0000_0F50, 1, 0, 5'd4, 6'd8, 1);
    req("R5", 1, 32'h0000_0750, 1, 0, 5'd4, 6'd8, 1);
    req("R4", 1, 32'h8000_0000, 1, 0, 5'd31, 6'd1, 0);
    req("R5", 1, 32'h8000_0000, 1, 0, 5'd31, 6'd1, 1);
    // R6 truncation at bit 31
    req("R6", 1, 32'hB000_0000, 1, 0, 5'd28, 6'd12, 0);
    req("R6", 1, 32'hB000_0000, 1, 0, 5'd28, 6'd12, 1);
    // R7 full word
    req("R7", 1, 32'h8765_4321, 1, 0, 5'd0, 6'd32, 0);
    req("R7", 1, 32'h8765_4321, 1, 0, 5'd0, 6'd32, 1);
    // R10 zero width
    req("R10", 1, 32'hFFFF_FFFF, 1, 0, 5'd5, 6'd0, 1);
    // reset while a request is present (R9)
    rst = 1'b1;
    req("R9", 1, 32'hFFFF_FFFF, 0, 2'b00, 0, 0, 0);
    rst = 1'b0;
    // back-to-back mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic f, sx;
      logic [5:0] w;
      f  = 1'($urandom);
      sx = 1'($urandom);
      w  = 6'(1 + ($urandom % 32));
      req(f ? (sx ? "R5" : "R4") : "R1", ($urandom % 4) != 0, $urandom, f,
          2'($urandom), 5'($urandom), w, sx);
    end
    req("R8", 0, 32'h0, 0, 0, 0, 0, 0);
    done = 1'b1;
    report();
  end
endmodule